// File: doc/BRIEF.md
# Byte-Register UART Core with Receive and Transmit Queues

This block is the host-facing half of a classic byte-wide UART. A host selects one of eight byte registers with a 3-bit offset and a one-cycle read or write strobe. Behind those registers sit a receive queue and a transmit queue, a baud divisor, a line control byte, a scratch byte, an interrupt enable mask and an interrupt identifier that ranks pending causes. The serial shifter is a separate block. It delivers each received byte through a push strobe and takes bytes to send through a valid/pop pair. It also reports whether its shift register is idle.

When the queues are switched off, each one holds a single byte, as in the older unbuffered parts. When they are switched on, each holds `DEPTH` (16) bytes, and the receive-data interrupt waits until the receive count reaches a level that the host picks. One small state machine tracks the transmit-empty interrupt. It has two states, `TXE_QUIET` and `TXE_PEND`. `TXE_QUIET` goes to `TXE_PEND` when the last byte of the transmit queue is popped, or when the host sets the transmit-empty enable bit while the queue is empty. `TXE_PEND` goes back to `TXE_QUIET` on a write to the transmit holding register, or on a read of the identification register while transmit-empty is the cause it reports.

Top module: `uart_regfile_core`

## Requirements
- R1: After reset, the line status register at offset 5 reads 60h when the shifter is idle, the identification register at offset 2 reads 01h, the modem status register at offset 6 reads 00h, `baud_div` is 0 and `irq` is low.
- R2: The scratch register at offset 7 returns the last byte written to it, for example AAh.
- R3: While line control bit 7 is set, offsets 0 and 1 reach the low and high divisor bytes, and `baud_div` equals {high, low}. Writing 03h to line control (offset 3) clears bit 7, so offsets 0 and 1 reach the data and enable registers again.
- R4: A write to offset 2 with bit 0 set turns the queues on, and bit 0 clear turns them off. While the queues are on, reads of offset 2 return bits 7:6 = 11. Any change of the enable bit empties both queues.
- R5: With the queues on, each holds DEPTH bytes in arrival order. With the queues off, each holds one byte.
- R6: A receive push into a full queue is dropped and sets line status bit 1 (overrun). A read of line status clears the overrun bit.
- R7: Bits 7:6 of a write to offset 2 select the receive trigger level: 00=1, 01=4, 10=8, 11=14 bytes. The trigger level is 1 while the queues are off. The received-data cause is pending when enable bit 0 (offset 1) is set and the receive count is at or above the trigger level.
- R8: The identifier in bits 3:0 of offset 2 reports the highest pending cause. The codes in falling priority are 0110 (overrun, enable bit 2), 0100 (received data), 0010 (transmit empty, enable bit 1) and 0001 (none).
- R9: The transmit-empty cause follows the `TXE_QUIET`/`TXE_PEND` machine described above.
- R10: A write to offset 2 with bit 1 set empties the receive queue. A write with bit 2 set empties the transmit queue.
- R11: Line status bit 0 is set when the receive queue is not empty. Bit 5 is set when the transmit queue is empty. Bit 6 is set when the transmit queue is empty and `tx_shift_idle` is high.
- R12: `irq` is high exactly when some enabled cause is pending. Its value follows from the identifier (not 0001).
- R13: A read of offset 0 with bit 7 clear returns the oldest received byte and removes it. Bytes written to offset 0 appear on `tx_byte` in order, with `tx_valid` high, one per `tx_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle; read side effects happen at the edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected offset |
| baud_div | output | 16 | Divisor {high, low} |
| rx_push | input | 1 | Received byte strobe from the shifter |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Shifter takes `tx_byte` |
| tx_shift_idle | input | 1 | Shifter has nothing in flight |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest state to reach is one where two causes are pending at once: overrun stacked on top of a receive queue already past its trigger level. The stimulus reaches it with 17 pushes into an enabled 16-byte queue at trigger level 14. It then checks that the identifier reports 0110, that a status read drops it to 0100, and that all 16 stored bytes drain in order. The transmit-empty machine is driven through both of its entry arcs and both of its exit arcs. Those arcs are the enable-bit arming, the drain by the last pop, the identification read and the holding write.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;

    localparam logic [2:0] OFS_DATA      = 3'd0;
    localparam logic [2:0] OFS_ENABLE    = 3'd1;
    localparam logic [2:0] OFS_IDENT     = 3'd2;
    localparam logic [2:0] OFS_LINE_CTL  = 3'd3;
    localparam logic [2:0] OFS_MODEM_CTL = 3'd4;
    localparam logic [2:0] OFS_LINE_STAT = 3'd5;
    localparam logic [2:0] OFS_MODEM_STA = 3'd6;
    localparam logic [2:0] OFS_SCRATCH   = 3'd7;

    typedef enum logic [3:0] {
        ID_LINE    = 4'b0110,
        ID_RXDATA  = 4'b0100,
        ID_TXEMPTY = 4'b0010,
        ID_NONE    = 4'b0001
    } int_id_e;

    typedef enum logic {
        TXE_QUIET = 1'b0,
        TXE_PEND  = 1'b1
    } txe_state_e;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          single_mode,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = single_mode ? CW'(1) : CW'(DEPTH);
    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_core_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    ier,
    input  logic          overrun,
    input  logic [CW-1:0] rx_count,
    input  logic [1:0]    trig_sel,
    input  logic          fifo_en,
    input  logic          tx_empty,
    input  logic          tx_drained,
    input  logic          ier_wr,
    input  logic          ier_wbit1,
    input  logic          thr_wr,
    input  logic          ident_rd,
    output int_id_e       id,
    output logic          txe_pending,
    output logic          irq
);
    txe_state_e    state, state_nx;
    logic [CW-1:0] threshold;
    logic          arm, line_hit, rx_hit, tx_hit;

    assign arm       = ier_wr && ier_wbit1 && !ier[1] && tx_empty;
    assign threshold = fifo_en ? CW'(trig_level(trig_sel)) : CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXE_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TXE_QUIET: if (!thr_wr && (tx_drained || arm)) state_nx = TXE_PEND;
            TXE_PEND:  if (thr_wr || (ident_rd && id == ID_TXEMPTY)) state_nx = TXE_QUIET;
        endcase
    end

    always_comb begin
        line_hit    = ier[2] && overrun;
        rx_hit      = ier[0] && (rx_count >= threshold);
        txe_pending = (state == TXE_PEND);
        tx_hit      = ier[1] && txe_pending;
        if (line_hit)    id = ID_LINE;
        else if (rx_hit) id = ID_RXDATA;
        else if (tx_hit) id = ID_TXEMPTY;
        else             id = ID_NONE;
        irq = (id != ID_NONE);
    end
endmodule

// File: rtl/uart_regfile_core.sv
module uart_regfile_core
    import uart_core_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic [15:0] baud_div,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    input  logic        tx_pop,
    input  logic        tx_shift_idle,
    output logic        irq
);
    logic [7:0]    lcr, scr, dll, dlm;
    logic [4:0]    mcr;
    logic [2:0]    ier;
    logic [1:0]    trig_sel;
    logic          fifo_en, overrun, dlab;
    logic          wr_thr, wr_dll, wr_ier, wr_dlm, wr_fcr, wr_lcr, wr_mcr, wr_scr;
    logic          rd_rbr, rd_iir, rd_lsr;
    logic          en_flip, rx_clear, tx_clear, tx_drained;
    logic [7:0]    rx_head, lsr;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_full, rx_empty, tx_full, tx_empty, txe_pending;
    int_id_e       id;

    assign dlab   = lcr[7];
    assign wr_thr = host_wr && host_addr == OFS_DATA     && !dlab;
    assign wr_dll = host_wr && host_addr == OFS_DATA     &&  dlab;
    assign wr_ier = host_wr && host_addr == OFS_ENABLE   && !dlab;
    assign wr_dlm = host_wr && host_addr == OFS_ENABLE   &&  dlab;
    assign wr_fcr = host_wr && host_addr == OFS_IDENT;
    assign wr_lcr = host_wr && host_addr == OFS_LINE_CTL;
    assign wr_mcr = host_wr && host_addr == OFS_MODEM_CTL;
    assign wr_scr = host_wr && host_addr == OFS_SCRATCH;
    assign rd_rbr = host_rd && host_addr == OFS_DATA     && !dlab;
    assign rd_iir = host_rd && host_addr == OFS_IDENT;
    assign rd_lsr = host_rd && host_addr == OFS_LINE_STAT;

    assign en_flip    = wr_fcr && (host_wdata[0] != fifo_en);
    assign rx_clear   = wr_fcr && (host_wdata[1] || en_flip);
    assign tx_clear   = wr_fcr && (host_wdata[2] || en_flip);
    assign tx_drained = tx_pop && (tx_count == CW'(1)) && !wr_thr && !tx_clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr      <= '0;
            scr      <= '0;
            dll      <= '0;
            dlm      <= '0;
            mcr      <= '0;
            ier      <= '0;
            trig_sel <= '0;
            fifo_en  <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (wr_lcr) lcr <= host_wdata;
            if (wr_scr) scr <= host_wdata;
            if (wr_dll) dll <= host_wdata;
            if (wr_dlm) dlm <= host_wdata;
            if (wr_mcr) mcr <= host_wdata[4:0];
            if (wr_ier) ier <= host_wdata[2:0];
            if (wr_fcr) begin
                fifo_en  <= host_wdata[0];
                trig_sel <= host_wdata[7:6];
            end
            if (rx_push && rx_full) overrun <= 1'b1;
            else if (rd_lsr)        overrun <= 1'b0;
        end
    end

    uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .clear(rx_clear), .single_mode(!fifo_en),
        .push(rx_push), .din(rx_byte), .pop(rd_rbr), .dout(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .clear(tx_clear), .single_mode(!fifo_en),
        .push(wr_thr), .din(host_wdata), .pop(tx_pop), .dout(tx_byte),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    uart_irq_ident #(.DEPTH(DEPTH)) u_ident (
        .clk(clk), .rst_n(rst_n), .ier(ier), .overrun(overrun),
        .rx_count(rx_count), .trig_sel(trig_sel), .fifo_en(fifo_en),
        .tx_empty(tx_empty), .tx_drained(tx_drained), .ier_wr(wr_ier),
        .ier_wbit1(host_wdata[1]), .thr_wr(wr_thr), .ident_rd(rd_iir),
        .id(id), .txe_pending(txe_pending), .irq(irq)
    );

    assign lsr      = {1'b0, tx_empty && tx_shift_idle, tx_empty, 3'b000, overrun, !rx_empty};
    assign baud_div = {dlm, dll};
    assign tx_valid = !tx_empty;

    always_comb begin
        unique case (host_addr)
            OFS_DATA:      host_rdata = dlab ? dll : rx_head;
            OFS_ENABLE:    host_rdata = dlab ? dlm : {5'b0, ier};
            OFS_IDENT:     host_rdata = {fifo_en, fifo_en, 2'b00, id};
            OFS_LINE_CTL:  host_rdata = lcr;
            OFS_MODEM_CTL: host_rdata = {3'b000, mcr};
            OFS_LINE_STAT: host_rdata = lsr;
            OFS_MODEM_STA: host_rdata = 8'h00;
            default:       host_rdata = scr;
        endcase
    end
endmodule

// File: rtl/uart_regfile_core_chk.sv
module uart_regfile_core_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    host_addr,
    input logic          host_wr,
    input logic [7:0]    host_wdata,
    input logic [7:0]    lcr,
    input logic [7:0]    scr,
    input logic [2:0]    ier,
    input logic          fifo_en,
    input logic          overrun,
    input logic          rx_push,
    input logic          rx_full,
    input logic [CW-1:0] rx_count,
    input logic          txe_pending,
    input logic          irq
);
    assert_rx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    assert_drop_sets_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> overrun);

    assert_enable_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd2) |=> (fifo_en == $past(host_wdata[0])));

    assert_masked_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 3'b000) |-> !irq);

    assert_holding_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd0 && !lcr[7]) |=> !txe_pending);

    assert_scratch_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd7) |=> (scr == $past(host_wdata)));

    assert_line_ctl_dlab_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd3 && host_wdata == 8'h03) |=> !lcr[7]);
endmodule

bind uart_regfile_core uart_regfile_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .lcr(lcr), .scr(scr), .ier(ier), .fifo_en(fifo_en),
    .overrun(overrun), .rx_push(rx_push), .rx_full(rx_full), .rx_count(rx_count),
    .txe_pending(txe_pending), .irq(irq)
);

// File: tb/uart_regfile_core_test.sv
module uart_regfile_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [15:0] baud_div;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_pop = 1'b0;
    logic        tx_shift_idle = 1'b1;
    logic        irq;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    uart_regfile_core uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .baud_div(baud_div), .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_pop(tx_pop),
        .tx_shift_idle(tx_shift_idle), .irq(irq)
    );

    // {read, offset, data, expected read value, requirement number}
    localparam logic [23:0] VEC [12] = '{
        {1'b0, 3'd7, 8'hAA, 8'h00, 4'd2},
        {1'b1, 3'd7, 8'h00, 8'hAA, 4'd2},
        {1'b0, 3'd3, 8'h80, 8'h00, 4'd3},
        {1'b0, 3'd1, 8'h00, 8'h00, 4'd3},
        {1'b0, 3'd0, 8'h30, 8'h00, 4'd3},
        {1'b1, 3'd0, 8'h00, 8'h30, 4'd3},
        {1'b0, 3'd3, 8'h03, 8'h00, 4'd3},
        {1'b0, 3'd1, 8'h00, 8'h00, 4'd3},
        {1'b1, 3'd3, 8'h00, 8'h03, 4'd3},
        {1'b1, 3'd5, 8'h00, 8'h60, 4'd11},
        {1'b1, 3'd6, 8'h00, 8'h00, 4'd1},
        {1'b1, 3'd2, 8'h00, 8'h01, 4'd8}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #2 check(req, {8'h00, host_rdata}, {8'h00, exp});
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop(input logic [7:0] exp, input string req);
        @(negedge clk);
        check(req, {7'b0, tx_valid, tx_byte}, {7'b0, 1'b1, exp});
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd5, 8'h60, "R1 line status");
        rd(3'd2, 8'h01, "R1 ident");
        @(negedge clk);
        check("R1 divisor/irq/valid", {baud_div[13:0], irq, tx_valid}, 16'h0000);

        foreach (VEC[i]) begin
            if (VEC[i][23]) rd(VEC[i][22:20], VEC[i][11:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
            else            wr(VEC[i][22:20], VEC[i][19:12]);
        end
        @(negedge clk);
        check("R3 divisor", baud_div, 16'h0030);
        rd(3'd1, 8'h00, "R3 enable register back");

        // R4 enable queues, trigger 14
        wr(3'd2, 8'hC1);
        rd(3'd2, 8'hC1, "R4 signature");
        wr(3'd1, 8'h05);
        for (int k = 0; k < 13; k++) push(8'h10 + 8'(k));
        check("R7 below trigger 14", {15'b0, irq}, 16'h0);
        push(8'h1D);
        check("R7 at trigger 14", {15'b0, irq}, 16'h1);
        rd(3'd2, 8'hC4, "R8 rx data code");
        push(8'h1E); push(8'h1F);
        push(8'hEE); // 17th: dropped
        rd(3'd2, 8'hC6, "R8 overrun outranks rx data");
        rd(3'd5, 8'h63, "R6 overrun set");
        rd(3'd5, 8'h61, "R6 overrun cleared by status read");
        rd(3'd2, 8'hC4, "R8 rx data after overrun clear");
        for (int k = 0; k < 16; k++) rd(3'd0, 8'h10 + 8'(k), "R13 R5 receive order");
        rd(3'd5, 8'h60, "R11 receive drained, dropped byte absent");

        // R7 trigger 4, R10 receive clear
        wr(3'd2, 8'h41);
        push(8'h01); push(8'h02); push(8'h03);
        check("R7 below trigger 4", {15'b0, irq}, 16'h0);
        push(8'h04);
        check("R7 at trigger 4", {15'b0, irq}, 16'h1);
        wr(3'd2, 8'h43);
        rd(3'd5, 8'h60, "R10 receive cleared");
        check("R10 irq after clear", {15'b0, irq}, 16'h0);

        // R9 transmit-empty machine
        wr(3'd1, 8'h02);
        check("R9 arm on enable", {15'b0, irq}, 16'h1);
        rd(3'd2, 8'hC2, "R9 tx empty code");
        rd(3'd2, 8'hC1, "R9 cleared by ident read");
        wr(3'd0, 8'hA1); wr(3'd0, 8'hA2); wr(3'd0, 8'hA3);
        rd(3'd5, 8'h00, "R11 transmit busy");
        pop(8'hA1, "R13 tx order"); pop(8'hA2, "R13 tx order");
        check("R9 not yet drained", {15'b0, irq}, 16'h0);
        pop(8'hA3, "R13 tx order");
        check("R9 drain sets", {15'b0, irq}, 16'h1);
        wr(3'd0, 8'h55);
        check("R9 holding write clears", {15'b0, irq}, 16'h0);
        wr(3'd2, 8'h05);
        rd(3'd5, 8'h60, "R10 transmit cleared");
        tx_shift_idle = 1'b0;
        rd(3'd5, 8'h20, "R11 shifter busy");
        tx_shift_idle = 1'b1;

        // R5 single-byte mode
        wr(3'd2, 8'h00);
        rd(3'd2, 8'h01, "R4 signature off");
        push(8'h11); push(8'h22);
        rd(3'd5, 8'h63, "R5 single byte overrun");
        rd(3'd0, 8'h11, "R5 single byte kept");
        rd(3'd5, 8'h60, "R5 single byte drained");
        finish_run();
    end
endmodule